// File: doc/BRIEF.md
# Latency-Modeled Shared Line Memory

This block is a small word-addressed storage array in which every four consecutive words form a line. It models a slow memory that two requesters share: a data port and an instruction-fetch port. Each access is a single-word write, a whole-line write or a whole-line read. A requester holds its request high on every cycle. It receives a wait response until a configurable number of cycles has passed, then one OK response that completes the access. The first requester to start an access keeps the memory until that access completes. While it does, the other requester only waits.

A third sideband port ignores both the latency and the ownership. It completes any access on the cycle it is presented. It is meant for preloading and inspecting the array without disturbing the timing of the two modeled requesters. Responses and read data are combinational from the current request. Writes commit at the clock edge that closes the OK cycle.

Top module: `line_mem_lat`

## Requirements
- R1: After reset every word of every line reads as zero, and with no request present every response is idle.
- R2: With latency N greater than zero, a request held alone on consecutive cycles returns WAIT on its first N cycles and OK on cycle N+1.
- R3: With latency zero, an access returns OK in the cycle it is first presented, and a read sees data written by an earlier completed access.
- R4: A write alters the stored line only at the clock edge that ends its OK cycle. During its WAIT cycles and during the OK cycle itself, the stored contents read back unchanged.
- R5: While one of the data and fetch ports owns the memory, the other port gets WAIT on every cycle it requests, including the owner's OK cycle. Two ports never see OK in the same cycle.
- R6: Ownership is released at the edge after the OK cycle. A port that was waiting then needs a full N WAIT cycles of its own before its OK.
- R7: A line read (op code 2) at any word address returns the whole line that holds it, with word k on bits 32k+31:32k. Read data is zero on any cycle without OK.
- R8: A word write (op code 0) replaces only the word picked by address bits 1:0, in the line picked by the upper address bits.
- R9: A line write (op code 1) replaces all four words of the addressed line.
- R10: A sideband request always returns OK in the cycle it is presented, and it does not change the latency count of an access in progress.
- R11: Responses are 2 bits per port: 0 idle (no request), 1 WAIT, 2 OK. The value 3 never appears.
- R12: If the owning port drops its request before its OK, ownership and the count return to idle, and a later request starts a fresh N-cycle count.
- R13: When the data and fetch ports both request in the same cycle while the memory is free, the data port becomes the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d_req | input | 1 | Data port request, held until OK |
| d_op | input | 2 | Data port operation: 0 word write, 1 line write, 2 line read |
| d_addr | input | ADDR_W | Data port word address |
| d_wword | input | 32 | Data port word to write |
| d_wline | input | 128 | Data port line to write |
| d_resp | output | 2 | Data port response |
| d_rline | output | 128 | Data port read line, valid on OK |
| f_req | input | 1 | Fetch port request, held until OK |
| f_op | input | 2 | Fetch port operation |
| f_addr | input | ADDR_W | Fetch port word address |
| f_wword | input | 32 | Fetch port word to write |
| f_wline | input | 128 | Fetch port line to write |
| f_resp | output | 2 | Fetch port response |
| f_rline | output | 128 | Fetch port read line, valid on OK |
| s_req | input | 1 | Sideband request, completes at once |
| s_op | input | 2 | Sideband operation |
| s_addr | input | ADDR_W | Sideband word address |
| s_wword | input | 32 | Sideband word to write |
| s_wline | input | 128 | Sideband line to write |
| s_resp | output | 2 | Sideband response |
| s_rline | output | 128 | Sideband read line |

## Verification
The assertions assume that a requester keeps its operation and address stable while its request is high and waiting. They also assume that the op code 3 is never driven. The stimulus holds every field of a request constant from its first cycle through its OK cycle and draws op codes only from 0 to 2. Sideband accesses are kept to reads while a modeled access is being checked, except in the one directed case that writes a different line.

// File: rtl/line_mem_pkg.sv
package line_mem_pkg;

    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int SEL_W      = $clog2(LINE_WORDS);
    localparam int LINE_W     = WORD_W * LINE_WORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_WAIT = 2'd1,
        RSP_OK   = 2'd2
    } resp_e;

    typedef enum logic [1:0] {
        OP_WR_WORD = 2'd0,
        OP_WR_LINE = 2'd1,
        OP_RD_LINE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_DATA  = 2'd1,
        OWN_FETCH = 2'd2
    } owner_e;

    function automatic logic op_writes(input logic [1:0] op);
        return (op == OP_WR_WORD) || (op == OP_WR_LINE);
    endfunction

    function automatic line_t merge_word(input line_t base,
                                         input logic [SEL_W-1:0] sel,
                                         input word_t w);
        line_t r;
        r = base;
        r[sel*WORD_W +: WORD_W] = w;
        return r;
    endfunction

endpackage

// File: rtl/line_mem_arb.sv
module line_mem_arb
    import line_mem_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       d_req,
    input  logic       f_req,
    output logic [1:0] d_resp,
    output logic [1:0] f_resp,
    output logic       d_done,
    output logic       f_done
);

    localparam int CNT_W = (LATENCY < 1) ? 1 : $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LATENCY);

    owner_e           owner_q, owner_eff, cur, owner_d;
    logic [CNT_W-1:0] cnt_q, cnt_eff, cnt_d;
    logic             done;

    always_comb begin
        owner_eff = owner_q;
        if (owner_q == OWN_DATA && !d_req)  owner_eff = OWN_NONE;
        if (owner_q == OWN_FETCH && !f_req) owner_eff = OWN_NONE;

        if (owner_eff == OWN_NONE) begin
            cnt_eff = '0;
            if (d_req)      cur = OWN_DATA;
            else if (f_req) cur = OWN_FETCH;
            else            cur = OWN_NONE;
        end else begin
            cnt_eff = cnt_q;
            cur     = owner_eff;
        end

        done = (cur != OWN_NONE) && (cnt_eff == LAT_C);

        if (cur == OWN_NONE || done) begin
            owner_d = OWN_NONE;
            cnt_d   = '0;
        end else begin
            owner_d = cur;
            cnt_d   = cnt_eff + 1'b1;
        end
    end

    assign d_done = done && (cur == OWN_DATA);
    assign f_done = done && (cur == OWN_FETCH);

    always_comb begin
        d_resp = !d_req ? RSP_IDLE : (d_done ? RSP_OK : RSP_WAIT);
        f_resp = !f_req ? RSP_IDLE : (f_done ? RSP_OK : RSP_WAIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_NONE;
            cnt_q   <= '0;
        end else begin
            owner_q <= owner_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/line_mem_store.sv
module line_mem_store
    import line_mem_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NRD       = 3,
    parameter int NWR       = 2,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NWR-1:0]             wr_en,
    input  logic [NWR-1:0][IDX_W-1:0]  wr_idx,
    input  logic [NWR-1:0][LINE_W-1:0] wr_line,
    input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NRD-1:0][LINE_W-1:0] rd_line
);

    line_t mem [NUM_LINES];

    // Later write ports take precedence on a shared line.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) mem[i] <= '0;
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (wr_en[w]) mem[wr_idx[w]] <= wr_line[w];
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_line[r] = mem[rd_idx[r]];
    end

endmodule

// File: rtl/line_mem_lat.sv
module line_mem_lat
    import line_mem_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int LATENCY   = 3,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int ADDR_W   = IDX_W + SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d_req,
    input  logic [1:0]        d_op,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [31:0]       d_wword,
    input  logic [127:0]      d_wline,
    output logic [1:0]        d_resp,
    output logic [127:0]      d_rline,
    input  logic              f_req,
    input  logic [1:0]        f_op,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic [31:0]       f_wword,
    input  logic [127:0]      f_wline,
    output logic [1:0]        f_resp,
    output logic [127:0]      f_rline,
    input  logic              s_req,
    input  logic [1:0]        s_op,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [31:0]       s_wword,
    input  logic [127:0]      s_wline,
    output logic [1:0]        s_resp,
    output logic [127:0]      s_rline
);

    localparam int NP = 3;   // 0 data, 1 fetch, 2 sideband

    logic [NP-1:0][1:0]        op;
    logic [NP-1:0][ADDR_W-1:0] addr;
    logic [NP-1:0][WORD_W-1:0] wword;
    logic [NP-1:0][LINE_W-1:0] wline;
    logic [NP-1:0][1:0]        resp;
    logic [NP-1:0][IDX_W-1:0]  idx;
    logic [NP-1:0][LINE_W-1:0] cur_line, new_line, rline;
    logic [NP-1:0]             is_wr;

    logic                      d_done, f_done;
    logic [1:0]                wr_en;
    logic [1:0][IDX_W-1:0]     wr_idx;
    logic [1:0][LINE_W-1:0]    wr_line;

    assign op    = {s_op,    f_op,    d_op};
    assign addr  = {s_addr,  f_addr,  d_addr};
    assign wword = {s_wword, f_wword, d_wword};
    assign wline = {s_wline, f_wline, d_wline};

    line_mem_arb #(.LATENCY(LATENCY)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .d_req  (d_req),
        .f_req  (f_req),
        .d_resp (resp[0]),
        .f_resp (resp[1]),
        .d_done (d_done),
        .f_done (f_done)
    );

    assign resp[2] = s_req ? RSP_OK : RSP_IDLE;

    for (genvar p = 0; p < NP; p++) begin : g_port
        assign idx[p]      = addr[p][ADDR_W-1:SEL_W];
        assign is_wr[p]    = op_writes(op[p]);
        assign new_line[p] = (op[p] == OP_WR_WORD)
                           ? merge_word(cur_line[p], addr[p][SEL_W-1:0], wword[p])
                           : wline[p];
        assign rline[p]    = (resp[p] == RSP_OK && !is_wr[p]) ? cur_line[p] : '0;
    end

    // Write port 0 carries the completing modeled access, port 1 the sideband.
    assign wr_en[0]   = (d_done && is_wr[0]) || (f_done && is_wr[1]);
    assign wr_idx[0]  = f_done ? idx[1] : idx[0];
    assign wr_line[0] = f_done ? new_line[1] : new_line[0];
    assign wr_en[1]   = s_req && is_wr[2];
    assign wr_idx[1]  = idx[2];
    assign wr_line[1] = new_line[2];

    line_mem_store #(.NUM_LINES(NUM_LINES), .NRD(NP), .NWR(2)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_line (wr_line),
        .rd_idx  (idx),
        .rd_line (cur_line)
    );

    assign d_resp  = resp[0];
    assign f_resp  = resp[1];
    assign s_resp  = resp[2];
    assign d_rline = rline[0];
    assign f_rline = rline[1];
    assign s_rline = rline[2];

endmodule

// File: rtl/line_mem_lat_chk.sv
module line_mem_lat_chk #(
    parameter int LATENCY = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         d_req,
    input logic         f_req,
    input logic         s_req,
    input logic [1:0]   d_resp,
    input logic [1:0]   f_resp,
    input logic [1:0]   s_resp,
    input logic [127:0] d_rline,
    input logic [127:0] f_rline
);

    logic seen_q;
    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    a_r11_no_code3: assert property (@(posedge clk) disable iff (rst)
        (d_resp != 2'd3) && (f_resp != 2'd3) && (s_resp != 2'd3));

    a_r11_idle_without_req: assert property (@(posedge clk) disable iff (rst)
        (!d_req |-> d_resp == 2'd0) and (!f_req |-> f_resp == 2'd0));

    a_r5_single_ok: assert property (@(posedge clk) disable iff (rst)
        !((d_resp == 2'd2) && (f_resp == 2'd2)));

    a_r5_loser_waits: assert property (@(posedge clk) disable iff (rst)
        ((d_resp == 2'd2) && f_req) |-> (f_resp == 2'd1));

    a_r10_side_immediate: assert property (@(posedge clk) disable iff (rst)
        s_req |-> (s_resp == 2'd2));

    a_r7_quiet_data: assert property (@(posedge clk) disable iff (rst)
        ((d_resp != 2'd2) |-> (d_rline == '0)) and ((f_resp != 2'd2) |-> (f_rline == '0)));

    if (LATENCY > 0) begin : g_lat
        a_r2_wait_before_ok: assert property (@(posedge clk) disable iff (rst || !seen_q)
            (d_resp == 2'd2) |-> ($past(d_resp) == 2'd1));
        a_r6_fetch_wait_before_ok: assert property (@(posedge clk) disable iff (rst || !seen_q)
            (f_resp == 2'd2) |-> ($past(f_resp) == 2'd1));
    end

endmodule

bind line_mem_lat line_mem_lat_chk #(.LATENCY(LATENCY)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .d_req   (d_req),
    .f_req   (f_req),
    .s_req   (s_req),
    .d_resp  (d_resp),
    .f_resp  (f_resp),
    .s_resp  (s_resp),
    .d_rline (d_rline),
    .f_rline (f_rline)
);

// File: tb/line_mem_lat_bench.sv
module line_mem_lat_bench;

    localparam int NL = 16;
    localparam int LAT = 3;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic d_req = 0, f_req = 0, s_req = 0;
    logic [1:0] d_op = 0, f_op = 0, s_op = 0;
    logic [AW-1:0] d_addr = 0, f_addr = 0, s_addr = 0;
    logic [31:0] d_wword = 0, f_wword = 0, s_wword = 0;
    logic [127:0] d_wline = 0, f_wline = 0, s_wline = 0;
    logic [1:0] d_resp, f_resp, s_resp;
    logic [127:0] d_rline, f_rline, s_rline;

    line_mem_lat #(.NUM_LINES(NL), .LATENCY(LAT)) u_line_mem_lat (
        .clk(clk), .rst(rst),
        .d_req(d_req), .d_op(d_op), .d_addr(d_addr), .d_wword(d_wword), .d_wline(d_wline),
        .d_resp(d_resp), .d_rline(d_rline),
        .f_req(f_req), .f_op(f_op), .f_addr(f_addr), .f_wword(f_wword), .f_wline(f_wline),
        .f_resp(f_resp), .f_rline(f_rline),
        .s_req(s_req), .s_op(s_op), .s_addr(s_addr), .s_wword(s_wword), .s_wline(s_wline),
        .s_resp(s_resp), .s_rline(s_rline)
    );

    // Zero-latency instance (R3)
    logic z_req = 0;
    logic [1:0] z_op = 0;
    logic [AW-1:0] z_addr = 0;
    logic [127:0] z_wline = 0;
    logic [1:0] z_resp, zf_resp, zs_resp;
    logic [127:0] z_rline, zf_rline, zs_rline;

    line_mem_lat #(.NUM_LINES(NL), .LATENCY(0)) u_line_mem_lat_z (
        .clk(clk), .rst(rst),
        .d_req(z_req), .d_op(z_op), .d_addr(z_addr), .d_wword(32'd0), .d_wline(z_wline),
        .d_resp(z_resp), .d_rline(z_rline),
        .f_req(1'b0), .f_op(2'd0), .f_addr('0), .f_wword(32'd0), .f_wline(128'd0),
        .f_resp(zf_resp), .f_rline(zf_rline),
        .s_req(1'b0), .s_op(2'd0), .s_addr('0), .s_wword(32'd0), .s_wline(128'd0),
        .s_resp(zs_resp), .s_rline(zs_rline)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [127:0] mdl [NL];

    function automatic logic [127:0] put_word(logic [127:0] l, logic [1:0] sel, logic [31:0] w);
        logic [127:0] r = l;
        r[sel*32 +: 32] = w;
        return r;
    endfunction

    function automatic logic [127:0] rnd_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic side_rd(int idx, output logic [127:0] l);
        @(negedge clk);
        s_req = 1; s_op = 2; s_addr = AW'(idx * 4);
        #1;
        chk("R10 side ok", 128'(s_resp), 128'd2);
        l = s_rline;
        s_req = 0;
    endtask

    task automatic do_access(bit fetch, logic [1:0] op, logic [AW-1:0] a,
                             logic [31:0] ww, logic [127:0] wl,
                             output int waits, output logic [127:0] rd);
        waits = 0;
        rd = '0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (fetch) begin f_req = 1; f_op = op; f_addr = a; f_wword = ww; f_wline = wl; end
            else       begin d_req = 1; d_op = op; d_addr = a; d_wword = ww; d_wline = wl; end
            #1;
            if ((fetch ? f_resp : d_resp) == 2'd2) begin
                rd = fetch ? f_rline : d_rline;
                break;
            end
            waits++;
        end
        @(negedge clk);
        d_req = 0; f_req = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] l, la, lb;
        int w;
        void'($urandom(32'h1a2b3c4d));
        for (int i = 0; i < NL; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        #1;
        chk("R1 d idle", 128'(d_resp), 128'd0);
        chk("R11 f idle", 128'(f_resp), 128'd0);
        for (int i = 0; i < NL; i++) begin
            side_rd(i, l);
            chk("R1 zero line", l, 128'd0);
        end

        // R2, R4, R9: line write to line 2, watched through the sideband
        la = rnd_line();
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            d_req = 1; d_op = 1; d_addr = 6'd8; d_wline = la;
            s_req = 1; s_op = 2; s_addr = 6'd9;
            #1;
            chk("R2 write line resp", 128'(d_resp), (c < 4) ? 128'd1 : 128'd2);
            chk("R4 unchanged before edge", s_rline, 128'd0);
            chk("R10 side ok", 128'(s_resp), 128'd2);
        end
        @(negedge clk);
        d_req = 0; s_req = 0;
        mdl[2] = la;
        side_rd(2, l);
        chk("R9 line written", l, la);

        // R7: read at addr 11 returns line 2, zero data during wait
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            d_req = 1; d_op = 2; d_addr = 6'd11;
            #1;
            chk("R7 read data", d_rline, (c < 4) ? 128'd0 : la);
        end
        @(negedge clk); d_req = 0;

        // R8: word write at addr 10 touches only word 2
        do_access(0, 2'd0, 6'd10, 32'hcafe0001, '0, w, l);
        chk("R8 wait count", 128'(w), 128'(LAT));
        mdl[2] = put_word(mdl[2], 2'd2, 32'hcafe0001);
        side_rd(2, l);
        chk("R8 word only", l, mdl[2]);

        // R13, R5, R6: simultaneous start, data wins, fetch restarts its count
        lb = rnd_line();
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (c == 1) begin
                d_req = 1; d_op = 1; d_addr = 6'd12; d_wline = lb;
                f_req = 1; f_op = 2; f_addr = 6'd13;
            end
            if (c == 5) d_req = 0;
            #1;
            if (c <= 4) chk("R13 data first", 128'(d_resp), (c < 4) ? 128'd1 : 128'd2);
            chk("R5 R6 fetch resp", 128'(f_resp), (c < 8) ? 128'd1 : 128'd2);
            if (c == 8) chk("R6 fetch reads line", f_rline, lb);
        end
        @(negedge clk); f_req = 0;
        mdl[3] = lb;

        // R5: fetch first, data joins a cycle later
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (c == 1) begin f_req = 1; f_op = 2; f_addr = 6'd0; end
            if (c == 2) begin d_req = 1; d_op = 2; d_addr = 6'd14; end
            if (c == 5) f_req = 0;
            #1;
            if (c <= 4) chk("R5 fetch owner", 128'(f_resp), (c < 4) ? 128'd1 : 128'd2);
            if (c >= 2) chk("R5 data waits", 128'(d_resp), (c < 8) ? 128'd1 : 128'd2);
        end
        @(negedge clk); d_req = 0;

        // R12: drop before OK restarts the count
        for (int c = 1; c <= 7; c++) begin
            @(negedge clk);
            d_op = 2; d_addr = 6'd4;
            d_req = (c != 3);
            #1;
            if (c == 3)      chk("R12 dropped idle", 128'(d_resp), 128'd0);
            else if (c < 7)  chk("R12 fresh wait", 128'(d_resp), 128'd1);
            else             chk("R12 ok after restart", 128'(d_resp), 128'd2);
        end
        @(negedge clk); d_req = 0;

        // R10: sideband write mid-count leaves the count alone
        la = rnd_line();
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            d_req = 1; d_op = 0; d_addr = 6'd1; d_wword = 32'h0badf00d;
            s_req = (c == 2); s_op = 1; s_addr = 6'd20; s_wline = la;
            #1;
            if (c == 2) chk("R10 side write ok", 128'(s_resp), 128'd2);
            chk("R10 count kept", 128'(d_resp), (c < 4) ? 128'd1 : 128'd2);
        end
        @(negedge clk); d_req = 0; s_req = 0;
        mdl[0] = put_word(mdl[0], 2'd1, 32'h0badf00d);
        mdl[5] = la;
        side_rd(5, l);
        chk("R10 side line stored", l, la);

        // R3: zero latency instance
        la = rnd_line();
        @(negedge clk);
        z_req = 1; z_op = 1; z_addr = 6'd16; z_wline = la;
        #1;
        chk("R3 write ok at once", 128'(z_resp), 128'd2);
        @(negedge clk);
        z_op = 2; z_addr = 6'd19;
        #1;
        chk("R3 read ok at once", 128'(z_resp), 128'd2);
        chk("R3 read data", z_rline, la);
        @(negedge clk); z_req = 0;

        // Random accesses on one port at a time (R2, R7, R8, R9)
        for (int k = 0; k < 60; k++) begin
            bit fp;
            logic [1:0] op;
            logic [AW-1:0] a;
            logic [31:0] ww;
            logic [127:0] wl;
            fp = 1'($urandom % 2);
            op = 2'($urandom % 3);
            a  = AW'($urandom);
            ww = $urandom;
            wl = rnd_line();
            do_access(fp, op, a, ww, wl, w, l);
            chk("R2 random wait count", 128'(w), 128'(LAT));
            if (op == 2) chk("R7 random read", l, mdl[a[5:2]]);
            else if (op == 1) mdl[a[5:2]] = wl;
            else mdl[a[5:2]] = put_word(mdl[a[5:2]], a[1:0], ww);
        end
        for (int i = 0; i < NL; i++) begin
            side_rd(i, l);
            chk("R8 R9 final contents", l, mdl[i]);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_fail);
        $finish;
    end

endmodule